// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Mode Control

This block holds eight single-bit outputs. One bit at a time is written from a serial data input, and a 3-bit address picks that bit. An active-low enable and an active-high clear together choose one of four modes. In addressed write, only the chosen bit takes the data and the others keep their values. In hold, nothing changes. In demultiplex, the chosen bit takes the data and every other bit goes low. In wipe, all bits go low. It serves as a serial-to-parallel register, as a bank of individually set flags, or as a one-of-eight decoder with a data gate.

The model is synchronous. Enable, clear, address and data are sampled on the rising edge of the system clock, and the outputs come from registers. In addressed write mode, changing more than one address bit at a time can hit the wrong bit. For that reason an address change between two back-to-back write cycles raises a one-cycle hazard flag. With the guard parameter set, the write in that cycle is also refused.

Top module: `addr_latch8`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, all outputs `q` and the flag `addr_hazard` are 0 after that edge, whatever the mode inputs are.
- R2: With `en_n`=0 and `clr`=0 (addressed write), after the edge `q[addr]` equals `din`, where bit index equals the binary address value, and all other bits of `q` keep their previous values.
- R3: With `en_n`=1 and `clr`=0 (hold), `q` is unchanged after the edge, whatever `addr` and `din` are.
- R4: With `en_n`=0 and `clr`=1 (demultiplex), after the edge `q[addr]` equals `din` and every other bit of `q` is 0.
- R5: With `en_n`=1 and `clr`=1 (wipe), `q` is all zeros after the edge.
- R6: `addr_hazard` is high for exactly the one cycle after an edge that sampled addressed write mode with an address different from the one sampled at the immediately preceding edge, which was also addressed write mode. Otherwise it is low.
- R7: With `GUARD`=1, an addressed write that raises `addr_hazard` leaves `q` unchanged. The next addressed write at the same address is accepted.
- R8: Values held before demultiplex mode are lost. A return to hold mode keeps only the single bit that demultiplex mode left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Write enable, active low |
| clr | input | 1 | Clear select, active high |
| addr | input | ADDR_W (3) | Bit select |
| din | input | 1 | Serial data bit |
| q | output | 2**ADDR_W (8) | Latched outputs, bit index equals address |
| addr_hazard | output | 1 | One-cycle flag for an address change between back-to-back write cycles |

## Verification
The bench targets these corner cases:
- Hold mode with the address and data toggling. A design that decodes hold as a write would pick up stray bits.
- A demultiplex pass over a full register, followed by hold. A design that ORs the selected bit into old contents, instead of zeroing the others, would keep stale ones.
- Consecutive writes with a changed address, which must raise the flag and, with the guard on, refuse the write.
- Entering write mode from hold at a new address, which must not raise the flag. A design that compares against addresses sampled in any mode would raise it falsely.
- Reset asserted while in write mode. A design that lets the mode decode override reset would leave bits set.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int ADDR_W = 3,
  parameter bit GUARD  = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_n,
  input  logic                     clr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     din,
  output logic [(1<<ADDR_W)-1:0]   q,
  output logic                     addr_hazard
);
  localparam int N = 1 << ADDR_W;

  logic [N-1:0]      sel;
  logic              wr_m, dmx_m, wipe_m;
  logic              prev_w;
  logic [ADDR_W-1:0] prev_a;
  logic              moved, block;

  assign sel    = {{(N-1){1'b0}}, 1'b1} << addr;
  assign wr_m   = !en_n && !clr;
  assign dmx_m  = !en_n &&  clr;
  assign wipe_m =  en_n &&  clr;
  assign moved  = wr_m && prev_w && (addr != prev_a);
  assign block  = GUARD && moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      q           <= '0;
      prev_w      <= 1'b0;
      prev_a      <= '0;
      addr_hazard <= 1'b0;
    end else begin
      prev_w      <= wr_m;
      prev_a      <= addr;
      addr_hazard <= moved;
      if (wr_m && !block) q <= (q & ~sel) | (sel & {N{din}});
      else if (dmx_m)     q <= sel & {N{din}};
      else if (wipe_m)    q <= '0;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (q == '0 && !addr_hazard));

  assert_write_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr) |=> (addr_hazard || q[$past(addr)] == $past(din)));

  assert_write_others_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr) |=>
      (((q ^ $past(q)) & ~({{(N-1){1'b0}}, 1'b1} << $past(addr))) == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr) |=> $stable(q));

  assert_demux_R4: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr) |=>
      (q == (({{(N-1){1'b0}}, 1'b1} << $past(addr)) & {N{$past(din)}})));

  assert_wipe_R5: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr) |=> (q == '0));

  assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr) ##1 (!en_n && !clr && addr != $past(addr)) |=> addr_hazard);

  assert_flag_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (en_n || clr) |=> !addr_hazard);

  assert_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (GUARD && addr_hazard) |-> (q == $past(q)));
endmodule

// File: tb/tb_addr_latch8.sv
module tb_addr_latch8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1, clr = 1'b0, din = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] q;
  logic       addr_hazard;

  int runs = 0, fails = 0;
  logic [7:0] exp_q = '0;
  logic       exp_pw = 1'b0;
  logic [2:0] exp_pa = '0;

  always #5 clk = ~clk;

  addr_latch8 dut (.clk(clk), .rst(rst), .en_n(en_n), .clr(clr),
                   .addr(addr), .din(din), .q(q), .addr_hazard(addr_hazard));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One clock: drive on falling edge, model the requirements, check after rising edge.
  task automatic cyc(input logic r, input logic e, input logic c,
                     input logic [2:0] a, input logic d, input string tag);
    logic [7:0] one;
    logic       haz;
    string      qtag;
    @(negedge clk);
    rst = r; en_n = e; clr = c; addr = a; din = d;
    one  = 8'b1 << a;
    haz  = 1'b0;
    qtag = tag;
    if (r) begin
      exp_q = '0; exp_pw = 1'b0; exp_pa = '0;
    end else begin
      haz = !e && !c && exp_pw && (a != exp_pa);
      if (!e && !c) begin
        if (haz) qtag = "R7";
        else exp_q = (exp_q & ~one) | (one & {8{d}});
      end else if (!e && c) exp_q = one & {8{d}};
      else if (e && c) exp_q = '0;
      exp_pw = !e && !c;
      exp_pa = a;
    end
    @(posedge clk); #1;
    chk(qtag, q, exp_q);
    chk("R6", {7'b0, addr_hazard}, {7'b0, haz});
  endtask

  task automatic t_reset;
    cyc(1, 0, 0, 3'd4, 1, "R1");
    cyc(1, 1, 1, 3'd0, 1, "R1");
    cyc(0, 0, 0, 3'd6, 1, "R2");
    cyc(1, 0, 0, 3'd6, 1, "R1");
  endtask

  task automatic t_write;
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, 0, 3'(i), 1'(i % 2), "R3");
      cyc(0, 0, 0, 3'(i), 1'(i % 2), "R2");
    end
    cyc(0, 1, 0, 3'd3, 0, "R3");
    cyc(0, 0, 0, 3'd3, 0, "R2");
    cyc(0, 0, 0, 3'd3, 1, "R2");
  endtask

  task automatic t_hold;
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 3'(7 - i), 1'(i % 2), "R3");
  endtask

  task automatic t_demux_then_hold;
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, 0, 3'(i), 1, "R3");
      cyc(0, 0, 0, 3'(i), 1, "R2");
    end
    cyc(0, 0, 1, 3'd5, 1, "R4");
    cyc(0, 1, 0, 3'd1, 1, "R8");
    chk("R8", q, 8'b0010_0000);
    cyc(0, 0, 1, 3'd2, 0, "R4");
    cyc(0, 0, 1, 3'd7, 1, "R4");
    cyc(0, 1, 0, 3'd0, 0, "R8");
  endtask

  task automatic t_wipe;
    cyc(0, 1, 0, 3'd2, 1, "R3");
    cyc(0, 0, 0, 3'd2, 1, "R2");
    cyc(0, 1, 1, 3'd2, 1, "R5");
    chk("R5", q, 8'h00);
  endtask

  task automatic t_hazard;
    cyc(0, 1, 0, 3'd2, 1, "R3");
    cyc(0, 0, 0, 3'd2, 1, "R2");
    cyc(0, 0, 0, 3'd5, 1, "R7");
    chk("R7", q, 8'b0000_0100);
    cyc(0, 0, 0, 3'd5, 1, "R2");
    chk("R7", q, 8'b0010_0100);
    cyc(0, 1, 0, 3'd6, 0, "R3");
    cyc(0, 0, 0, 3'd1, 1, "R2");
    chk("R6", {7'b0, addr_hazard}, 8'h00);
    cyc(0, 0, 1, 3'd3, 1, "R4");
    cyc(0, 0, 0, 3'd4, 1, "R2");
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    cyc(1, 1, 0, 3'd0, 0, "R1");
    chk("R1", q, 8'h00);
    t_reset;
    t_write;
    t_hold;
    t_demux_then_hold;
    t_wipe;
    t_hazard;
    t_reset;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule